// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the station-management master that talks to an Ethernet PHY over the two-wire management bus. Software puts the whole frame body into a 32-bit command register as one literal word: start code, opcode, PHY address, register address, turnaround and 16 data bits. The write starts the transfer. The block sends 32 preamble ones and then the command word on the data line, most significant bit first, while it toggles the management clock.

For a read, the master lets go of the data line from the turnaround onward. It shifts in the 16 bits that the PHY returns and, when the frame ends, puts them in the low half of the command register. The end of every frame gives a one-cycle done pulse and sets a sticky event bit that software clears by writing a one. The management clock rate comes from a 6-bit divisor field. Each clock half period lasts that many system clocks, so software picks the divisor to keep the bus clock within the PHY's limit.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, mdc, mdio_oe, mdio_out and done are low, and the command, speed and event registers all read zero.
- R2: mdc is low whenever no frame runs. During a frame each mdc high or low phase lasts exactly divisor system clocks, and a frame has exactly 64 mdc rising edges.
- R3: A frame puts 32 ones on mdio_out, then command bits 31 down to 0. Within a frame, mdio_out changes only together with an mdc falling edge.
- R4: A command whose bits 29:28 are 10 is a read. For a read, mdio_oe is high for the first 46 bit times (preamble plus command bits 31:18) and low for turnaround and data. For any other opcode, mdio_oe is high for all 64 bit times.
- R5: For a read, mdio_in is sampled on the 16 mdc rising edges of command bits 15:0, MSB first. At the end of the frame the sampled value replaces bits 15:0 of the command register, and bits 31:16 are kept.
- R6: done is a single-cycle pulse that comes with the last mdc falling edge of a frame. It sets bit 0 of the event register (address 2). Writing 1 to that bit clears it, and writing 0 leaves it set.
- R7: A write to the command register (address 0) while a frame runs, or in the done cycle, is ignored. The register keeps its value and the frame in progress is unchanged.
- R8: With a divisor of zero, a command write is stored but starts no frame: mdc stays low and no done occurs.
- R9: The speed register (address 1) keeps the divisor in bits 6:1. All its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write address: 0 command, 1 speed, 2 event |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 2 | Read address, same map |
| reg_rd_data | output | 32 | Read data for reg_rd_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_in | input | 1 | Data line value seen from the bus |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong bit index or opcode decode shows up within one frame as a mismatched bit at an mdc rising edge, or as mdio_oe dropping at the wrong bit time. The scoreboard compares all 64 bit times at the done pulse. A divider that counts wrong changes the spacing between mdc edges at once, and the spacing is measured at every toggle. Errors in capture or write-protection show up at the first register read after done, which returns either the wrong low half or a command value that a blocked write should not have changed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_W     = 32;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + CMD_W;
    localparam int DATA_W    = 16;
    localparam int TA_MSB    = 17;
    localparam int DIV_W     = 6;
    localparam int DIV_LSB   = 1;
    localparam int REG_AW    = 2;
    localparam int EVT_DONE_BIT = 0;

    localparam logic [REG_AW-1:0] RA_CMD   = 2'd0;
    localparam logic [REG_AW-1:0] RA_SPEED = 2'd1;
    localparam logic [REG_AW-1:0] RA_EVENT = 2'd2;

    localparam logic [1:0] OPC_READ = 2'b10;

    typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;

    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [1:0]  ta;
        logic [15:0] data;
    } mgmt_cmd_t;

    function automatic logic cmd_is_read(input mgmt_cmd_t c);
        return c.op == OPC_READ;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIVW = mdio_pkg::DIV_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            mdc,
    output logic            rise,
    output logic            fall
);
    logic [DIVW-1:0] cnt_q;
    logic            mdc_q;
    logic            wrap;

    // half period reached: count+1 has met the divisor
    assign wrap = run && (({1'b0, cnt_q} + (DIVW+1)'(1)) >= {1'b0, div});
    assign rise = wrap && !mdc_q;
    assign fall = wrap && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + DIVW'(1);
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter import mdio_pkg::*; #(
    parameter int FRAME = FRAME_LEN,
    parameter int PRE   = PRE_LEN,
    parameter int CAPW  = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            rise,
    input  logic            fall,
    input  mgmt_cmd_t       cmd,
    input  logic            mdio_in,
    output logic            busy,
    output logic            mdio_out,
    output logic            mdio_oe,
    output logic            done,
    output logic [CAPW-1:0] cap
);
    localparam int IDX_W   = $clog2(FRAME);
    localparam int CIW     = $clog2(CMD_W);
    localparam int LAST    = FRAME - 1;
    localparam int TA_IDX  = PRE + (CMD_W - 1 - TA_MSB);
    localparam int DAT_IDX = FRAME - CAPW;

    sh_state_e        state_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic [CAPW-1:0]  cap_q;

    logic [IDX_W-1:0] pos;
    logic [CMD_W-1:0] cmd_bits;
    logic             bit_now;
    logic             is_rd;
    logic             released;

    always_comb begin
        cmd_bits = cmd;
        pos      = IDX_W'(LAST) - idx_q;
        bit_now  = (idx_q < IDX_W'(PRE)) ? 1'b1 : cmd_bits[pos[CIW-1:0]];
        is_rd    = cmd_is_read(cmd);
        released = is_rd && (idx_q >= IDX_W'(TA_IDX));
    end

    assign busy     = (state_q == SH_RUN);
    assign mdio_oe  = busy && !released;
    assign mdio_out = busy && !released && bit_now;
    assign done     = done_q;
    assign cap      = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
            cap_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SH_IDLE: begin
                    if (start) begin
                        state_q <= SH_RUN;
                        idx_q   <= '0;
                        cap_q   <= '0;
                    end
                end
                SH_RUN: begin
                    if (rise && is_rd && idx_q >= IDX_W'(DAT_IDX))
                        cap_q <= {cap_q[CAPW-2:0], mdio_in};
                    if (fall) begin
                        if (idx_q == IDX_W'(LAST)) begin
                            state_q <= SH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs import mdio_pkg::*; #(
    parameter int AW   = REG_AW,
    parameter int DIVW = DIV_W,
    parameter int CAPW = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [CMD_W-1:0] rd_data,
    input  logic             engaged,
    input  logic             done,
    input  logic [CAPW-1:0]  cap_data,
    output mgmt_cmd_t        cmd_q,
    output logic [DIVW-1:0]  div_q,
    output logic             start,
    output logic             evt_q
);
    logic wr_cmd, wr_speed, wr_event;

    assign wr_cmd   = wr_en && (wr_addr == RA_CMD);
    assign wr_speed = wr_en && (wr_addr == RA_SPEED);
    assign wr_event = wr_en && (wr_addr == RA_EVENT);
    assign start    = wr_cmd && !engaged && (div_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_cmd && !engaged) begin
            cmd_q <= mgmt_cmd_t'(wr_data);
        end else if (done && cmd_is_read(cmd_q)) begin
            cmd_q.data <= cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           div_q <= '0;
        else if (wr_speed) div_q <= wr_data[DIV_LSB +: DIVW];
    end

    always_ff @(posedge clk) begin
        if (rst)                                 evt_q <= 1'b0;
        else if (done)                           evt_q <= 1'b1;
        else if (wr_event && wr_data[EVT_DONE_BIT]) evt_q <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CMD:   rd_data = cmd_q;
            RA_SPEED: rd_data[DIV_LSB +: DIVW] = div_q;
            RA_EVENT: rd_data[EVT_DONE_BIT] = evt_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl import mdio_pkg::*; #(
    parameter int DIVW = DIV_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_wr_addr,
    input  logic [31:0] reg_wr_data,
    input  logic [1:0]  reg_rd_addr,
    output logic [31:0] reg_rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in,
    output logic        done
);
    mgmt_cmd_t         cmd_w;
    logic [DIVW-1:0]   div_w;
    logic              start_w, busy_w, done_w, evt_w;
    logic              rise_w, fall_w;
    logic [DATA_W-1:0] cap_w;

    mdio_regs #(.AW(REG_AW), .DIVW(DIVW), .CAPW(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .engaged(busy_w | done_w), .done(done_w), .cap_data(cap_w),
        .cmd_q(cmd_w), .div_q(div_w), .start(start_w), .evt_q(evt_w)
    );

    mdio_clkgen #(.DIVW(DIVW)) u_clk (
        .clk(clk), .rst(rst), .run(busy_w), .div(div_w),
        .mdc(mdc), .rise(rise_w), .fall(fall_w)
    );

    mdio_shifter #(.FRAME(FRAME_LEN), .PRE(PRE_LEN), .CAPW(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .start(start_w), .rise(rise_w), .fall(fall_w),
        .cmd(cmd_w), .mdio_in(mdio_in), .busy(busy_w),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .done(done_w), .cap(cap_w)
    );

    assign done = done_w;
endmodule

module mdio_mgmt_sva (
    input logic clk,
    input logic rst,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe,
    input logic done,
    input logic busy,
    input logic evt
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst) done |-> $fell(mdc)); // R6
    AST_EVT_SET: assert property (@(posedge clk) disable iff (rst) done |=> evt); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mdc && !mdio_oe)); // R2
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdio_out)) |-> $fell(mdc)); // R3
    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdio_oe)) |-> $fell(mdc)); // R4
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_sva u_sva (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .done(done), .busy(busy_w), .evt(evt_w)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_out, mdio_oe, mdio_in, done;

    always #2.5 clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
        .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in),
        .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        int          div;
    } exp_t;
    exp_t sb_q[$];

    function automatic exp_t mk_exp(input logic [31:0] cmd, input int div);
        exp_t e;
        for (int k = 0; k < 64; k++) begin
            e.bits[k] = (k < 32) ? 1'b1 : cmd[63-k];
            e.oe[k]   = (cmd[29:28] == 2'b10) ? (k < 46) : 1'b1;
        end
        e.div = div;
        return e;
    endfunction

    // PHY model: returns phy_val on the data bit times
    logic [15:0] phy_val = '0;
    int          rise_cnt = 0;
    assign mdio_in = (rise_cnt >= 48 && rise_cnt <= 63) ? phy_val[4'(63 - rise_cnt)] : 1'b1;

    // monitor / scoreboard
    logic        mdc_prev = 1'b0;
    logic        prev_done = 1'b0;
    int          since = 0;
    int          per_err = 0;
    int          frames = 0;
    logic [63:0] got_b = '0;
    logic [63:0] got_oe = '0;

    always @(negedge clk) begin
        if (!rst) begin
            since++;
            if (mdc != mdc_prev) begin
                if (!(mdc && rise_cnt == 0) && sb_q.size() > 0 && since != sb_q[0].div)
                    per_err++;
                since = 0;
                if (mdc && rise_cnt < 64) begin
                    got_b[rise_cnt]  = mdio_out;
                    got_oe[rise_cnt] = mdio_oe;
                    rise_cnt++;
                end
            end
            if (done) begin
                chk(!prev_done, "R6 done longer than one cycle", 64'(prev_done), 64'd0);
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 done without a frame", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(rise_cnt == 64, "R2 mdc rising edges per frame", 64'(rise_cnt), 64'd64);
                    chk(((got_b ^ e.bits) & e.oe) == '0, "R3 frame bits", got_b, e.bits);
                    chk(got_oe == e.oe, "R4 output enable pattern", got_oe, e.oe);
                    chk(per_err == 0, "R2 half period length", 64'(per_err), 64'd0);
                end
                rise_cnt = 0;
                per_err  = 0;
                frames++;
            end
            mdc_prev  = mdc;
            prev_done = done;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic set_div(input int div);
        wr(2'd1, 32'(div) << 1);
    endtask

    task automatic run_frame(input logic [31:0] cmd, input int div, input logic [15:0] phyv, input bit intrude);
        logic [31:0] v;
        int f;
        phy_val = phyv;
        sb_q.push_back(mk_exp(cmd, div));
        f = frames;
        wr(2'd0, cmd);
        if (intrude) begin
            repeat (40) @(negedge clk);
            wr(2'd0, 32'h1234_5678);
            rd(2'd0, v);
            chk(v == cmd, "R7 command write during frame ignored", 64'(v), 64'(cmd));
        end
        wait (frames != f);
        rd(2'd0, v);
        if (cmd[29:28] == 2'b10)
            chk(v == {cmd[31:16], phyv}, "R5 read data capture", 64'(v), 64'({cmd[31:16], phyv}));
        else
            chk(v == cmd, "R5 write command kept", 64'(v), 64'(cmd));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(mdc == 1'b0, "R1 mdc after reset", 64'(mdc), 64'd0);
        chk(mdio_oe == 1'b0 && mdio_out == 1'b0, "R1 mdio after reset", 64'({mdio_oe, mdio_out}), 64'd0);
        chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
        rd(2'd0, v); chk(v == 0, "R1 command reg reset", 64'(v), 64'd0);
        rd(2'd1, v); chk(v == 0, "R1 speed reg reset", 64'(v), 64'd0);
        rd(2'd2, v); chk(v == 0, "R1 event reg reset", 64'(v), 64'd0);

        // R9 speed field position
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk(v == 32'h7E, "R9 speed field bits 6:1", 64'(v), 64'h7E);

        // R8 divisor zero: stored, no frame
        set_div(0);
        wr(2'd0, 32'h5002_ABCD);
        repeat (60) @(negedge clk);
        chk(rise_cnt == 0 && frames == 0 && mdc == 1'b0, "R8 no frame with zero divisor",
            64'(rise_cnt + frames), 64'd0);
        rd(2'd0, v); chk(v == 32'h5002_ABCD, "R8 command stored", 64'(v), 64'h5002_ABCD);

        // R3 R4 write frame, divisor 2
        set_div(2);
        run_frame(32'h5002_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'hA5C3, 2, 16'h0000, 1'b0);

        // R6 event behaviour
        rd(2'd2, v); chk(v == 32'h1, "R6 event set after frame", 64'(v), 64'd1);
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk(v == 32'h1, "R6 writing zero keeps event", 64'(v), 64'd1);
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk(v == 32'h0, "R6 write one clears event", 64'(v), 64'd0);

        // R4 R5 read frame
        run_frame(32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18), 2, 16'h9D1E, 1'b0);

        // R5 R7 read with stale low bits, divisor 1, intruding write
        set_div(1);
        run_frame(32'h6002_FFFF | (32'd31 << 23) | (32'd17 << 18), 1, 16'h0001, 1'b1);

        // R2 R3 write frame, divisor 3, zero data, intruding write
        set_div(3);
        run_frame(32'h5002_0000 | (32'd10 << 23) | (32'd31 << 18), 3, 16'hFFFF, 1'b1);

        // R5 read with alternating pattern
        run_frame(32'h6002_0000 | (32'd21 << 23) | (32'd9 << 18), 3, 16'h5AA5, 1'b0);

        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0 && frames == 5, "R6 one done per frame", 64'(frames), 64'd5);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule